// File: doc/BRIEF.md
# Seedable Stream Cipher Scrambler

This block whitens a serial transmit bit stream, one bit per clock, ahead of line coding. Every data bit that arrives with its valid strobe is XORed with the next bit of an 11-bit linear feedback shift register keystream. The result leaves one clock later together with a matching valid flag. The register moves on only for valid bits, so gaps in the stream do not use up keystream.

Software or a port controller can restart the keystream from a per-port seed by pulsing a load input. The seed has two parts. The upper bits hold the port's PHY address and the lower bits hold a user-chosen value. Ports that sit side by side in a repeater then produce keystreams that are out of step with one another, which spreads their combined emission spectrum. An all-zero seed would stall the register for good, so a fixed non-zero value takes its place.

Top module: `stream_scrambler`

## Requirements
- R1: While reset is asserted and on the first clock after it, `data_o` and `valid_o` are 0. After reset the register holds 11'h7FF, where bit k of the register is the keystream bit produced k+1 steps earlier.
- R2: The keystream follows X[n] = X[n-11] XOR X[n-9]. Each step makes a new bit X[n] from register bits 10 and 8, shifts the register left by one and puts X[n] into bit 0.
- R3: A bit accepted with `valid_i` = 1 appears on `data_o` one clock later as `data_i` XOR X[n]. X[n] is the keystream bit computed from the register contents in the accept cycle.
- R4: `valid_o` equals `valid_i` delayed by one clock.
- R5: The register steps only in cycles where `valid_i` = 1. In every other cycle without a load it holds its value.
- R6: A load pulse copies the seed {`phy_addr_i`, `user_seed_i`} into the register, with the address in bits [10:6] and the user seed in bits [5:0].
- R7: If the assembled seed is 0, the register loads 11'h5A5 instead. The register is never all zeros.
- R8: When a load and a valid bit fall in the same cycle, the load wins and the register does not step. The output bit of that cycle still uses the keystream bit from the register contents before the load.
- R9: `data_o` is 0 in every cycle where `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input bit is valid and steps the keystream |
| data_i | input | 1 | NRZ data bit to scramble |
| seed_load_i | input | 1 | Single-cycle request to load the seed |
| phy_addr_i | input | 5 | Port address, forms seed bits [10:6] |
| user_seed_i | input | 6 | User seed, forms seed bits [5:0] |
| data_o | output | 1 | Scrambled bit |
| valid_o | output | 1 | Scrambled bit is valid |

## Verification
A seed load and a valid data bit can arrive in the same cycle. In that cycle the output must use the pre-load keystream bit, and the register must take the seed and skip its step. The bench provokes this in three ways: a lone load-with-valid pulse inside a long valid run, back-to-back loads with valid held high, and a load-with-valid that carries an all-zero seed. It judges each case with a behavioural model, a queue of past keystream bits, that it compares with the outputs every clock. A wrong priority or a stray step then shows up as a shifted keystream in the bits that follow.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned SCR_W       = 11;
  localparam int unsigned SCR_TAP     = 9;
  localparam int unsigned SCR_ADDR_W  = 5;
  localparam int unsigned SCR_USEED_W = 6;
  localparam logic [SCR_W-1:0] SCR_RST_SEED = 11'h7FF;
  localparam logic [SCR_W-1:0] SCR_ZERO_SUB = 11'h5A5;
endpackage

// File: rtl/scr_seed_mux.sv
module scr_seed_mux #(
  parameter int unsigned W       = 11,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned USEED_W = 6,
  parameter logic [W-1:0] ZERO_SUB = 11'h5A5
) (
  input  logic [ADDR_W-1:0]  phy_addr_i,
  input  logic [USEED_W-1:0] user_seed_i,
  output logic [W-1:0]       seed_o
);
  logic [W-1:0] raw_seed;
  assign raw_seed = {phy_addr_i, user_seed_i};
  // all-zero state is a lock-up point of the recurrence
  assign seed_o = (raw_seed == '0) ? ZERO_SUB : raw_seed;
endmodule

// File: rtl/scr_lfsr_core.sv
module scr_lfsr_core #(
  parameter int unsigned W   = 11,
  parameter int unsigned TAP = 9,
  parameter logic [W-1:0] RST_SEED = 11'h7FF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  output logic         key_o,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;

  // bit k holds X[n-1-k]
  assign key_o   = state_q[W-1] ^ state_q[TAP-1];
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= RST_SEED;
    else if (load_i) state_q <= seed_i;
    else if (step_i) state_q <= {state_q[W-2:0], key_o};
  end
endmodule

// File: rtl/scr_out_stage.sv
module scr_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic data_i,
  input  logic key_i,
  output logic data_o,
  output logic valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      data_o  <= valid_i & (data_i ^ key_i);
      valid_o <= valid_i;
    end
  end
endmodule

// File: rtl/stream_scrambler.sv
module stream_scrambler
  import scr_pkg::*;
#(
  parameter int unsigned LFSR_W  = SCR_W,
  parameter int unsigned TAP     = SCR_TAP,
  parameter int unsigned ADDR_W  = SCR_ADDR_W,
  parameter int unsigned USEED_W = SCR_USEED_W,
  parameter logic [LFSR_W-1:0] RST_SEED = SCR_RST_SEED,
  parameter logic [LFSR_W-1:0] ZERO_SUB = SCR_ZERO_SUB
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               data_i,
  input  logic               seed_load_i,
  input  logic [ADDR_W-1:0]  phy_addr_i,
  input  logic [USEED_W-1:0] user_seed_i,
  output logic               data_o,
  output logic               valid_o
);
  logic [LFSR_W-1:0] seed;
  logic [LFSR_W-1:0] lfsr_state;
  logic              key;

  scr_seed_mux #(
    .W(LFSR_W), .ADDR_W(ADDR_W), .USEED_W(USEED_W), .ZERO_SUB(ZERO_SUB)
  ) u_seed (
    .phy_addr_i (phy_addr_i),
    .user_seed_i(user_seed_i),
    .seed_o     (seed)
  );

  scr_lfsr_core #(
    .W(LFSR_W), .TAP(TAP), .RST_SEED(RST_SEED)
  ) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (valid_i),
    .load_i (seed_load_i),
    .seed_i (seed),
    .key_o  (key),
    .state_o(lfsr_state)
  );

  scr_out_stage u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .data_i (data_i),
    .key_i  (key),
    .data_o (data_o),
    .valid_o(valid_o)
  );
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
  parameter int unsigned W       = 11,
  parameter int unsigned TAP     = 9,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned USEED_W = 6,
  parameter logic [W-1:0] ZERO_SUB = 11'h5A5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               data_i,
  input logic               seed_load_i,
  input logic [ADDR_W-1:0]  phy_addr_i,
  input logic [USEED_W-1:0] user_seed_i,
  input logic               data_o,
  input logic               valid_o,
  input logic [W-1:0]       state_i
);
  assert_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !seed_load_i |=> state_i[W-1:1] == $past(state_i[W-2:0]));

  assert_xor_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> data_o == ($past(data_i) ^ $past(state_i[W-1]) ^ $past(state_i[TAP-1])));

  assert_valid_delay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> valid_o == $past(valid_i));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !seed_load_i |=> $stable(state_i));

  assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i && ({phy_addr_i, user_seed_i} != '0) |=> state_i == $past({phy_addr_i, user_seed_i}));

  assert_zero_sub_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i && ({phy_addr_i, user_seed_i} == '0) |=> state_i == ZERO_SUB);

  assert_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != '0);

  assert_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !data_o);
endmodule

bind stream_scrambler scr_checker #(
  .W(LFSR_W), .TAP(TAP), .ADDR_W(ADDR_W), .USEED_W(USEED_W), .ZERO_SUB(ZERO_SUB)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .data_i     (data_i),
  .seed_load_i(seed_load_i),
  .phy_addr_i (phy_addr_i),
  .user_seed_i(user_seed_i),
  .data_o     (data_o),
  .valid_o    (valid_o),
  .state_i    (lfsr_state)
);

// File: tb/tb_stream_scrambler.sv
`timescale 1ns/1ps
module tb_stream_scrambler;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic       data_i = 1'b0;
  logic       seed_load_i = 1'b0;
  logic [4:0] phy_addr_i = '0;
  logic [5:0] user_seed_i = '0;
  logic       data_o;
  logic       valid_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  bit    hist[$];          // hist[k] = keystream bit from k+1 steps ago
  bit    exp_d = 1'b0;
  bit    exp_v = 1'b0;
  string exp_tag = "R1";

  always #2.5 clk_i = ~clk_i;

  stream_scrambler dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .seed_load_i(seed_load_i), .phy_addr_i(phy_addr_i), .user_seed_i(user_seed_i),
    .data_o(data_o), .valid_o(valid_o)
  );

  task automatic set_hist(input logic [10:0] v);
    hist.delete();
    for (int k = 0; k < 11; k++) hist.push_back(v[k]);
  endtask

  task automatic check_outs();
    checks++;
    if (data_o !== exp_d || valid_o !== exp_v) begin
      failures++;
      $display("FAIL %s data_o=%0b valid_o=%0b expected data_o=%0b valid_o=%0b",
               exp_tag, data_o, valid_o, exp_d, exp_v);
    end
  endtask

  task automatic cycle(input bit v, input bit d, input bit ld,
                       input logic [4:0] a, input logic [5:0] u, input string tag);
    bit key;
    logic [10:0] s;
    @(negedge clk_i);
    check_outs();
    valid_i = v; data_i = d; seed_load_i = ld; phy_addr_i = a; user_seed_i = u;
    key = hist[10] ^ hist[8];
    exp_v = v;
    exp_d = v ? (d ^ key) : 1'b0;
    exp_tag = tag;
    if (ld) begin
      s = {a, u};
      if (s == 11'd0) s = 11'h5A5;
      set_hist(s);
    end else if (v) begin
      hist.push_front(key);
      void'(hist.pop_back());
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    set_hist(11'h7FF);
    // R1: outputs quiet in reset, even with active inputs
    valid_i = 1'b1; data_i = 1'b1;
    repeat (3) begin
      @(negedge clk_i);
      exp_tag = "R1";
      check_outs();
    end
    valid_i = 1'b0; data_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1/R2: zero data exposes the keystream from the reset state
    for (int i = 0; i < 20; i++) cycle(1, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 100; i++) cycle(1, 0, 0, 0, 0, "R2");
    // R3: random data
    for (int i = 0; i < 200; i++) cycle(1, 1'($urandom), 0, 0, 0, "R3");
    // R4/R5/R9: gaps, data toggling while invalid
    for (int i = 0; i < 200; i++) cycle(1'($urandom), 1'($urandom), 0, 0, 0, "R5");
    for (int i = 0; i < 30; i++) cycle(1'(i % 3 == 0), 1, 0, 0, 0, "R4");
    for (int i = 0; i < 10; i++) cycle(0, 1, 0, 0, 0, "R9");
    // R6: seed loads without valid, two ports
    cycle(0, 0, 1, 5'h13, 6'h2A, "R6");
    for (int i = 0; i < 40; i++) cycle(1, 0, 0, 5'h13, 6'h2A, "R6");
    cycle(0, 0, 1, 5'h01, 6'h05, "R6");
    for (int i = 0; i < 40; i++) cycle(1, 1'($urandom), 0, 0, 0, "R6");
    // R7: zero seed substitution
    cycle(0, 0, 1, 5'h00, 6'h00, "R7");
    for (int i = 0; i < 40; i++) cycle(1, 0, 0, 0, 0, "R7");
    // R8: load together with valid
    for (int i = 0; i < 10; i++) cycle(1, 1'($urandom), 0, 0, 0, "R8");
    cycle(1, 1, 1, 5'h0A, 6'h11, "R8");
    for (int i = 0; i < 30; i++) cycle(1, 1'($urandom), 0, 0, 0, "R8");
    cycle(1, 0, 1, 5'h1F, 6'h3F, "R8");
    cycle(1, 1, 1, 5'h04, 6'h20, "R8");
    for (int i = 0; i < 30; i++) cycle(1, 0, 0, 0, 0, "R8");
    cycle(1, 1, 1, 5'h00, 6'h00, "R8");
    for (int i = 0; i < 30; i++) cycle(1, 1'($urandom), 0, 0, 0, "R8");
    cycle(0, 0, 0, 0, 0, "R4");
    @(negedge clk_i);
    check_outs();
    finish_run();
  end
endmodule